// File: doc/BRIEF.md
# FPU Status Register Updater

This block holds the 32-bit status word of a floating-point unit and brings it up to date after every arithmetic operation. The execution pipeline hands it the class and sign of the result together with an eight-bit vector of exception events raised by that operation. From these the block rebuilds the condition-code byte, overwrites the current-exception byte, folds the new events into the sticky accrued-exception byte and leaves the quotient byte as it was.

The same cycle's events are matched bit by bit against the exception-enable byte of the control register. Any overlap produces a one-cycle trap request towards the trap logic. Software can load the whole status word directly. Such a load wins over an operation arriving in the same cycle.

The block has no sequencing of its own: every update completes in one clock. The result class is carried as an enumerated type, and the register has a single process.

Top module: `fpsr_updater`

## Requirements
- R1: After reset the status word is 0x00000000 and `trap_req` is 0.
- R2: On an operation (`op_valid`=1, `sw_wr_en`=0), status bits 15:8 become `op_events` one for one. The event bit order is bit 7 branch/set on unordered, 6 signalling NaN, 5 operand error, 4 overflow, 3 underflow, 2 divide by zero, 1 inexact operation, 0 inexact decimal input.
- R3: An operation leaves the quotient byte (status bits 23:16) unchanged.
- R4: On an operation the condition byte (bits 31:24) is rewritten from `op_class` (0 zero, 1 ordinary number, 2 infinity, 3 NaN) and `op_sign`:
  - NaN gives 0x01, whatever the sign.
  - Infinity gives 0x02, plus 0x08 when the sign is 1.
  - Zero gives 0x04, plus 0x08 when the sign is 1.
  - An ordinary number gives 0x08 when the sign is 1 and 0x00 otherwise.
- R5: On an operation the accrued bits are OR-ed with the new events and never cleared:
  - bit 7 (invalid) takes events 7, 6 or 5.
  - bit 6 takes overflow (event 4).
  - bit 4 takes divide by zero (event 2).
  - bit 3 (inexact) takes events 1, 0 or 4.
- R6: Accrued underflow (bit 5) is set only when underflow (event 3) and inexact operation (event 1) occur in the same operation.
- R7: `trap_req` is 1 in the cycle after an operation whose `op_events & ctrl_enables` is nonzero, and 0 in every other cycle.
- R8: A software write (`sw_wr_en`=1) loads `sw_wr_data` with its reserved bits cleared. Any operation in the same cycle is ignored and raises no trap.
- R9: Status bits 31:28 and 2:0 always read 0.
- R10: With neither a write nor an operation the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Software load of the status word |
| sw_wr_data | input | 32 | Value for the software load |
| op_valid | input | 1 | An operation has completed this cycle |
| op_class | input | 2 | Result class: 0 zero, 1 number, 2 infinity, 3 NaN |
| op_sign | input | 1 | Result sign, 1 = negative |
| op_events | input | 8 | Exception events of the operation (R2 order) |
| ctrl_enables | input | 8 | Exception-enable byte of the control register |
| status | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The assertions take for granted that `op_class`, `op_events` and `ctrl_enables` are meaningful only when an update is taken. They also take for granted that a software write may coincide with an operation, which the priority rule covers. The stimulus therefore drives arbitrary events and classes on every cycle, including cycles with `op_valid` low. It mixes in writes both alone and together with operations, so that the hold, priority and sticky properties are each exercised. Directed cases cover every class and sign, underflow without inexact, and an all-ones software load that touches the reserved bits.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    localparam int STAT_W = 32;
    localparam int BYTE_W = 8;
    localparam int ACC_W  = 5;

    // Bits of the status word that are implemented (reserved bits clear)
    localparam logic [STAT_W-1:0] STAT_MASK = 32'h0FFF_FFF8;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } res_class_e;

    // Event bit positions, shared by the current byte and the enable byte
    localparam int EV_UNORD  = 7;
    localparam int EV_SNAN   = 6;
    localparam int EV_OPERR  = 5;
    localparam int EV_OVFL   = 4;
    localparam int EV_UNFL   = 3;
    localparam int EV_DZ     = 2;
    localparam int EV_INEXOP = 1;
    localparam int EV_INEXDI = 0;

endpackage

// File: rtl/fsu_cc_gen.sv
module fsu_cc_gen
    import fsu_pkg::*;
(
    input  res_class_e        cls,
    input  logic              sign,
    output logic [BYTE_W-1:0] cc_byte
);

    logic is_neg, is_zero, is_inf, is_nan;

    always_comb begin
        is_neg  = 1'b0;
        is_zero = 1'b0;
        is_inf  = 1'b0;
        is_nan  = 1'b0;
        unique case (cls)
            CLS_ZERO: begin
                is_zero = 1'b1;
                is_neg  = sign;
            end
            CLS_NUM: begin
                is_neg  = sign;
            end
            CLS_INF: begin
                is_inf  = 1'b1;
                is_neg  = sign;
            end
            CLS_NAN: begin
                is_nan  = 1'b1;
            end
        endcase
    end

    assign cc_byte = {4'b0000, is_neg, is_zero, is_inf, is_nan};

endmodule

// File: rtl/fsu_accrue.sv
module fsu_accrue
    import fsu_pkg::*;
(
    input  logic [BYTE_W-1:0] events,
    input  logic [ACC_W-1:0]  acc_old,
    output logic [ACC_W-1:0]  acc_new
);

    logic [ACC_W-1:0] acc_set;

    // acc_set[4..0] maps to status bits 7..3
    always_comb begin
        acc_set[4] = events[EV_UNORD] | events[EV_SNAN] | events[EV_OPERR];
        acc_set[3] = events[EV_OVFL];
        acc_set[2] = events[EV_UNFL] & events[EV_INEXOP];
        acc_set[1] = events[EV_DZ];
        acc_set[0] = events[EV_INEXOP] | events[EV_INEXDI] | events[EV_OVFL];
    end

    assign acc_new = acc_old | acc_set;

endmodule

// File: rtl/fsu_trap_match.sv
module fsu_trap_match
    import fsu_pkg::*;
(
    input  logic [BYTE_W-1:0] events,
    input  logic [BYTE_W-1:0] enables,
    output logic              hit
);

    logic [BYTE_W-1:0] lane;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        assign lane[g] = events[g] & enables[g];
    end

    assign hit = |lane;

endmodule

// File: rtl/fpsr_updater.sv
module fpsr_updater
    import fsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [STAT_W-1:0] sw_wr_data,
    input  logic              op_valid,
    input  logic [1:0]        op_class,
    input  logic              op_sign,
    input  logic [BYTE_W-1:0] op_events,
    input  logic [BYTE_W-1:0] ctrl_enables,
    output logic [STAT_W-1:0] status,
    output logic              trap_req
);

    logic [STAT_W-1:0] stat_q, stat_d;
    logic              trap_q, trap_d;
    logic [BYTE_W-1:0] cc_byte;
    logic [ACC_W-1:0]  acc_new;
    logic              hit;
    res_class_e        cls;

    assign cls = res_class_e'(op_class);

    fsu_cc_gen u_cc (
        .cls     (cls),
        .sign    (op_sign),
        .cc_byte (cc_byte)
    );

    fsu_accrue u_acc (
        .events  (op_events),
        .acc_old (stat_q[7:3]),
        .acc_new (acc_new)
    );

    fsu_trap_match u_trap (
        .events  (op_events),
        .enables (ctrl_enables),
        .hit     (hit)
    );

    always_comb begin
        stat_d = stat_q;
        trap_d = 1'b0;
        if (sw_wr_en) begin
            stat_d = sw_wr_data & STAT_MASK;
        end else if (op_valid) begin
            stat_d = {cc_byte, stat_q[23:16], op_events, acc_new, 3'b000};
            trap_d = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            trap_q <= 1'b0;
        end else begin
            stat_q <= stat_d;
            trap_q <= trap_d;
        end
    end

    assign status   = stat_q;
    assign trap_req = trap_q;

endmodule

// File: rtl/fpsr_updater_chk.sv
module fpsr_updater_chk
    import fsu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr_en,
    input logic [STAT_W-1:0] sw_wr_data,
    input logic              op_valid,
    input logic [1:0]        op_class,
    input logic [BYTE_W-1:0] op_events,
    input logic [STAT_W-1:0] status,
    input logic              trap_req
);

    p_quot_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && op_valid) |=> status[23:16] == $past(status[23:16]));

    p_events_copied_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && op_valid) |=> status[15:8] == $past(op_events));

    p_nan_cc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && op_valid && op_class == 2'd3) |=> status[31:24] == 8'h01);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> (status[7:3] & $past(status[7:3])) == $past(status[7:3]));

    p_trap_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid && !sw_wr_en));

    p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (status == ($past(sw_wr_data) & STAT_MASK)) && !trap_req);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !op_valid) |=> $stable(status));

    always @(negedge clk) begin
        if (rst_n) begin
            p_reserved_r9: assert (status[31:28] == 4'h0 && status[2:0] == 3'h0);
        end
    end

endmodule

bind fpsr_updater fpsr_updater_chk u_chk (.*);

// File: tb/fpsr_updater_tb.sv
module fpsr_updater_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_class = '0;
    logic        op_sign = 1'b0;
    logic [7:0]  op_events = '0;
    logic [7:0]  ctrl_enables = '0;
    logic [31:0] status;
    logic        trap_req;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_stat = '0;
    logic        exp_trap = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsr_updater u_dut (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .op_valid(op_valid), .op_class(op_class), .op_sign(op_sign),
        .op_events(op_events), .ctrl_enables(ctrl_enables),
        .status(status), .trap_req(trap_req)
    );

    function automatic logic [7:0] cc_of(logic [1:0] c, logic s);
        case (c)
            2'd0: return s ? 8'h0C : 8'h04;
            2'd1: return s ? 8'h08 : 8'h00;
            2'd2: return s ? 8'h0A : 8'h02;
            default: return 8'h01;
        endcase
    endfunction

    function automatic logic [4:0] acc_of(logic [7:0] e);
        return {e[7] | e[6] | e[5], e[4], e[3] & e[1], e[2], e[1] | e[0] | e[4]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R4 cc byte", {24'h0, status[31:24]}, {24'h0, exp_stat[31:24]});
        chk("R3 quotient", {24'h0, status[23:16]}, {24'h0, exp_stat[23:16]});
        chk("R2 current", {24'h0, status[15:8]}, {24'h0, exp_stat[15:8]});
        chk("R5 R6 accrued", {24'h0, status[7:0]}, {24'h0, exp_stat[7:0]});
        chk("R7 trap", {31'h0, trap_req}, {31'h0, exp_trap});
    endtask

    // drive at negedge, model the next posedge, check at the following negedge
    task automatic step(logic w, logic [31:0] wd, logic v, logic [1:0] c,
                        logic s, logic [7:0] e, logic [7:0] en);
        sw_wr_en = w; sw_wr_data = wd; op_valid = v; op_class = c;
        op_sign = s; op_events = e; ctrl_enables = en;
        exp_trap = 1'b0;
        if (w) begin
            exp_stat = wd & 32'h0FFF_FFF8;
        end else if (v) begin
            exp_stat = {cc_of(c, s), exp_stat[23:16], e, exp_stat[7:3] | acc_of(e), 3'b000};
            exp_trap = |(e & en);
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 32'h0);
        chk("R1 trap", {31'h0, trap_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 all-ones load clears reserved bits (R8)
        step(1, 32'hFFFF_FFFF, 0, 0, 0, 8'h00, 8'h00);
        chk("R9 reserved", status & 32'hF000_0007, 32'h0);
        step(1, 32'h00A5_0000, 0, 0, 0, 8'h00, 8'h00);
        // R4 every class and sign
        step(0, 0, 1, 2'd3, 1, 8'h00, 8'h00);
        step(0, 0, 1, 2'd2, 1, 8'h00, 8'h00);
        step(0, 0, 1, 2'd2, 0, 8'h00, 8'h00);
        step(0, 0, 1, 2'd0, 0, 8'h00, 8'h00);
        step(0, 0, 1, 2'd0, 1, 8'h00, 8'h00);
        step(0, 0, 1, 2'd1, 1, 8'h00, 8'h00);
        step(0, 0, 1, 2'd1, 0, 8'h00, 8'h00);
        // R6 underflow without inexact leaves accrued underflow clear
        step(0, 0, 1, 2'd1, 0, 8'h08, 8'h00);
        chk("R6 unfl alone", {31'h0, status[5]}, 32'h0);
        step(0, 0, 1, 2'd1, 0, 8'h0A, 8'h00);
        chk("R6 unfl+inex", {31'h0, status[5]}, 32'h1);
        // R5 accrued stays after an event-free op; R2 current cleared
        step(0, 0, 1, 2'd1, 0, 8'h00, 8'h00);
        chk("R5 sticky", {24'h0, status[7:0]}, 32'h28);
        // R7 trap on match and no trap without match
        step(0, 0, 1, 2'd1, 0, 8'h10, 8'h10);
        step(0, 0, 1, 2'd1, 0, 8'h10, 8'hEF);
        // R8 write together with op: op ignored, no trap
        step(1, 32'h1234_5678, 1, 2'd3, 1, 8'hFF, 8'hFF);
        // R10 idle holds
        step(0, 0, 0, 2'd3, 1, 8'hFF, 8'hFF);
        step(0, 0, 0, 2'd0, 0, 8'h55, 8'hFF);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            step(r[3:0] == 4'h0, $urandom, r[4] | r[5], r[7:6], r[8],
                 8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule